// File: doc/BRIEF.md
# Seek and Tune Channel Controller

This block steers a receiver across a broadcast band in steps of numbered channels. The host can make one of two requests. A tune request moves straight to a programmed channel. A seek request walks channel by channel, up or down, until it finds a station that passes every enabled quality criterion. At each channel the controller asks an external measurement port for three values: signal strength, signal-to-noise ratio and an impulse-noise count. It then judges the channel on those values. The synthesizer and the RF measurement itself sit outside this block.

The controller has two seek modes, chosen by a mode bit. In wrap mode the seek runs past one band edge onto the other. If it comes back to its starting channel without finding a station, it goes back to that channel and flags failure. In stop mode the seek halts at the band edge and flags failure there. When an operation ends, the completion flag is raised and held. It drops only after the host removes its request. The block also computes the tuned frequency in kHz from the channel, the channel spacing and the band.

The measurement port is two valid/ready channels. The request side carries the channel to measure. It holds valid, and keeps the channel stable, until ready is seen. The response side is accepted only while the controller raises ready. The measuring side may stall either side for any number of cycles, and the controller waits.

Top module: `seek_tune_ctrl`

## Requirements
- R1: When `tune_req` rises from idle, the controller measures exactly the channel on `chan_in` once, moves `cur_chan` to it, latches the returned RSSI in `rssi_last`, then raises `done` with `fail` low.
- R2: Once raised, `done` (and `fail`) hold while `tune_req` or `seek_req` is high. Within a cycle of both being low they clear, and no measurement is requested until a new request.
- R3: `freq_khz` equals the band bottom plus `cur_chan` times the spacing. `spacing_sel` 0 gives 200 kHz, 1 gives 100 kHz, and 2 or 3 give 50 kHz.
- R4: `band_sel` 0 is 87.5–108 MHz, 1 is 76–108 MHz, and 2 is 76–90 MHz (3 behaves as 1). The top channel is floor(band width / spacing), and a seek never measures above it.
- R5: A seek steps by one channel, upward when `seek_up` is 1 and downward otherwise. It accepts the first channel whose RSSI is at or above `rssi_thresh`, leaves `cur_chan` there, and raises `done` with `fail` low.
- R6: If `snr_thresh` is nonzero, an accepted channel also needs SNR at or above it. If `imp_thresh` is nonzero, an accepted channel also needs an impulse count at or below it. A value of 0 disables that criterion.
- R7: With `seek_stop` at 0, a seek passing the top channel continues at channel 0, and a seek passing channel 0 continues at the top channel.
- R8: With `seek_stop` at 0, if the seek comes back to its starting channel, it ends with `fail` high and `cur_chan` at the starting channel. The starting channel is never measured.
- R9: With `seek_stop` at 1, a seek that would step past a band edge ends with `fail` high and `cur_chan` at that edge, without measuring further.
- R10: During a seek, `cur_chan` changes at every step, and `meas_chan` equals `cur_chan` whenever a measurement is requested.
- R11: `meas_req_valid` stays high, with `meas_chan` stable, until `meas_req_ready` is seen. `meas_rsp_ready` is high only while a response is awaited, and never together with `meas_req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tune_req | input | 1 | Tune request, held until `done` is seen |
| seek_req | input | 1 | Seek request, held until `done` is seen |
| seek_up | input | 1 | Seek direction, 1 = upward |
| seek_stop | input | 1 | 1 = stop at band edge, 0 = wrap around |
| spacing_sel | input | 2 | Channel spacing select |
| band_sel | input | 2 | Band select |
| chan_in | input | 10 | Channel for a tune |
| rssi_thresh | input | 8 | Minimum RSSI for a seek stop |
| snr_thresh | input | 4 | Minimum SNR, 0 = unused |
| imp_thresh | input | 4 | Maximum impulse count, 0 = unused |
| meas_req_valid | output | 1 | Measurement request valid |
| meas_req_ready | input | 1 | Measurement request accepted |
| meas_chan | output | 10 | Channel to be measured |
| meas_rsp_valid | input | 1 | Measurement result valid |
| meas_rsp_ready | output | 1 | Controller waits for a result |
| meas_rssi | input | 8 | Measured RSSI |
| meas_snr | input | 4 | Measured SNR |
| meas_imp | input | 4 | Measured impulse count |
| done | output | 1 | Operation complete |
| fail | output | 1 | Seek failed or band edge reached |
| cur_chan | output | 10 | Current channel |
| rssi_last | output | 8 | RSSI of the last measured channel |
| freq_khz | output | 19 | Frequency of `cur_chan` in kHz |

## Verification
Tunes are run to channels in all three bands with each spacing, including the very top channel of a band. These tell a wrong band bottom apart from a wrong spacing multiplier. Seeks are run over a quiet background with one or two planted stations. The stations are given an RSSI exactly at the threshold, an SNR below its threshold, and an impulse count just over or exactly at its threshold. The outcome then separates each criterion, its disabling zero, and the inclusive or exclusive comparison. Wrap seeks in both directions and a full lap with no station distinguish edge wrapping from the return to the start. Stop-mode seeks, one beginning already at channel 0, check the edge halt. A tune with a throttled request ready shows that the measurement handshake waits correctly.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADV,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } stc_state_e;

  localparam logic [1:0] SPC_200 = 2'd0;
  localparam logic [1:0] SPC_100 = 2'd1;

  localparam logic [1:0] BND_WIDE_EU = 2'd0;
  localparam logic [1:0] BND_NARROW  = 2'd2;

  localparam int SPAN_W = 11;
endpackage

// File: rtl/stc_band_calc.sv
module stc_band_calc
  import stc_pkg::*;
#(
  parameter int CHAN_W = 10,
  parameter int FREQ_W = 19
) (
  input  logic [1:0]        band_sel,
  input  logic [1:0]        spacing_sel,
  output logic [FREQ_W-1:0] bottom_khz,
  output logic [7:0]        step_khz,
  output logic [CHAN_W-1:0] top_chan
);
  // band width counted in 50 kHz units
  logic [SPAN_W-1:0] span50;

  always_comb begin
    case (band_sel)
      BND_WIDE_EU: begin bottom_khz = FREQ_W'(87500); span50 = SPAN_W'(410); end
      BND_NARROW:  begin bottom_khz = FREQ_W'(76000); span50 = SPAN_W'(280); end
      default:     begin bottom_khz = FREQ_W'(76000); span50 = SPAN_W'(640); end
    endcase
  end

  always_comb begin
    case (spacing_sel)
      SPC_200: begin step_khz = 8'd200; top_chan = CHAN_W'(span50 >> 2); end
      SPC_100: begin step_khz = 8'd100; top_chan = CHAN_W'(span50 >> 1); end
      default: begin step_khz = 8'd50;  top_chan = CHAN_W'(span50);      end
    endcase
  end
endmodule

// File: rtl/stc_qualify.sv
module stc_qualify #(
  parameter int RSSI_W = 8,
  parameter int SNR_W  = 4,
  parameter int IMP_W  = 4
) (
  input  logic [RSSI_W-1:0] rssi,
  input  logic [SNR_W-1:0]  snr,
  input  logic [IMP_W-1:0]  imp,
  input  logic [RSSI_W-1:0] rssi_min,
  input  logic [SNR_W-1:0]  snr_min,
  input  logic [IMP_W-1:0]  imp_max,
  output logic              pass
);
  logic rssi_ok, snr_ok, imp_ok;

  always_comb begin
    rssi_ok = (rssi >= rssi_min);
    snr_ok  = (snr_min == '0) || (snr >= snr_min);
    imp_ok  = (imp_max == '0) || (imp <= imp_max);
    pass    = rssi_ok && snr_ok && imp_ok;
  end
endmodule

// File: rtl/stc_freq.sv
module stc_freq #(
  parameter int CHAN_W = 10,
  parameter int FREQ_W = 19
) (
  input  logic [CHAN_W-1:0] chan,
  input  logic [FREQ_W-1:0] bottom_khz,
  input  logic [7:0]        step_khz,
  output logic [FREQ_W-1:0] freq_khz
);
  logic [FREQ_W-1:0] offset;

  always_comb begin
    offset   = FREQ_W'(chan) * FREQ_W'(step_khz);
    freq_khz = bottom_khz + offset;
  end
endmodule

// File: rtl/seek_tune_ctrl.sv
module seek_tune_ctrl
  import stc_pkg::*;
#(
  parameter int CHAN_W = 10,
  parameter int RSSI_W = 8,
  parameter int SNR_W  = 4,
  parameter int IMP_W  = 4,
  parameter int FREQ_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tune_req,
  input  logic              seek_req,
  input  logic              seek_up,
  input  logic              seek_stop,
  input  logic [1:0]        spacing_sel,
  input  logic [1:0]        band_sel,
  input  logic [CHAN_W-1:0] chan_in,
  input  logic [RSSI_W-1:0] rssi_thresh,
  input  logic [SNR_W-1:0]  snr_thresh,
  input  logic [IMP_W-1:0]  imp_thresh,
  output logic              meas_req_valid,
  input  logic              meas_req_ready,
  output logic [CHAN_W-1:0] meas_chan,
  input  logic              meas_rsp_valid,
  output logic              meas_rsp_ready,
  input  logic [RSSI_W-1:0] meas_rssi,
  input  logic [SNR_W-1:0]  meas_snr,
  input  logic [IMP_W-1:0]  meas_imp,
  output logic              done,
  output logic              fail,
  output logic [CHAN_W-1:0] cur_chan,
  output logic [RSSI_W-1:0] rssi_last,
  output logic [FREQ_W-1:0] freq_khz
);
  stc_state_e        state;
  logic              op_seek;
  logic [CHAN_W-1:0] chan_q, start_q;
  logic [RSSI_W-1:0] rssi_q;
  logic              done_q, fail_q;

  logic [FREQ_W-1:0] bottom_khz;
  logic [7:0]        step_khz;
  logic [CHAN_W-1:0] top_chan;
  logic              station_ok;
  logic              at_edge;
  logic [CHAN_W-1:0] next_chan;

  stc_band_calc #(.CHAN_W(CHAN_W), .FREQ_W(FREQ_W)) u_band (
    .band_sel    (band_sel),
    .spacing_sel (spacing_sel),
    .bottom_khz  (bottom_khz),
    .step_khz    (step_khz),
    .top_chan    (top_chan)
  );

  stc_qualify #(.RSSI_W(RSSI_W), .SNR_W(SNR_W), .IMP_W(IMP_W)) u_qual (
    .rssi     (meas_rssi),
    .snr      (meas_snr),
    .imp      (meas_imp),
    .rssi_min (rssi_thresh),
    .snr_min  (snr_thresh),
    .imp_max  (imp_thresh),
    .pass     (station_ok)
  );

  stc_freq #(.CHAN_W(CHAN_W), .FREQ_W(FREQ_W)) u_freq (
    .chan       (chan_q),
    .bottom_khz (bottom_khz),
    .step_khz   (step_khz),
    .freq_khz   (freq_khz)
  );

  // one seek step: neighbour channel and whether a band edge blocks it
  always_comb begin
    if (seek_up) begin
      at_edge   = (chan_q >= top_chan);
      next_chan = at_edge ? '0 : chan_q + 1'b1;
    end else begin
      at_edge   = (chan_q == '0);
      next_chan = at_edge ? top_chan : chan_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_seek <= 1'b0;
      chan_q  <= '0;
      start_q <= '0;
      rssi_q  <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (tune_req) begin
            op_seek <= 1'b0;
            chan_q  <= chan_in;
            state   <= ST_REQ;
          end else if (seek_req) begin
            op_seek <= 1'b1;
            if (chan_q > top_chan) begin
              chan_q  <= top_chan;
              start_q <= top_chan;
            end else begin
              start_q <= chan_q;
            end
            state <= ST_ADV;
          end
        end
        ST_ADV: begin
          if (seek_stop && at_edge) begin
            fail_q <= 1'b1;
            done_q <= 1'b1;
            state  <= ST_DONE;
          end else if (!seek_stop && next_chan == start_q) begin
            chan_q <= start_q;
            fail_q <= 1'b1;
            done_q <= 1'b1;
            state  <= ST_DONE;
          end else begin
            chan_q <= next_chan;
            state  <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (meas_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (meas_rsp_valid) begin
            rssi_q <= meas_rssi;
            if (!op_seek || station_ok) begin
              done_q <= 1'b1;
              state  <= ST_DONE;
            end else begin
              state <= ST_ADV;
            end
          end
        end
        ST_DONE: begin
          if (!tune_req && !seek_req) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign meas_req_valid = (state == ST_REQ);
  assign meas_rsp_ready = (state == ST_WAIT);
  assign meas_chan      = chan_q;
  assign cur_chan       = chan_q;
  assign rssi_last      = rssi_q;
  assign done           = done_q;
  assign fail           = fail_q;

  // request stays up with a stable channel until taken (R11)
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req_valid && !meas_req_ready |=> meas_req_valid && $stable(meas_chan));

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(meas_req_valid && meas_rsp_ready));

  assert_done_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done && (tune_req || seek_req) |=> done);

  assert_done_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done && !tune_req && !seek_req |=> !done && !fail);

  assert_seek_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req_valid && op_seek && $stable(band_sel) && $stable(spacing_sel)
      |-> meas_chan <= top_chan);

  assert_wrap_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && fail && op_seek && !seek_stop |-> cur_chan == start_q);
endmodule

// File: tb/seek_tune_ctrl_tb.sv
module seek_tune_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tune_req = 1'b0, seek_req = 1'b0, seek_up = 1'b1, seek_stop = 1'b0;
  logic [1:0]  spacing_sel = 2'd0, band_sel = 2'd0;
  logic [9:0]  chan_in = '0;
  logic [7:0]  rssi_thresh = 8'd40;
  logic [3:0]  snr_thresh = 4'd0, imp_thresh = 4'd0;
  logic        meas_req_valid, meas_req_ready = 1'b0;
  logic [9:0]  meas_chan;
  logic        meas_rsp_valid = 1'b0, meas_rsp_ready;
  logic [7:0]  meas_rssi = '0;
  logic [3:0]  meas_snr = '0, meas_imp = '0;
  logic        done, fail;
  logic [9:0]  cur_chan;
  logic [7:0]  rssi_last;
  logic [18:0] freq_khz;

  int total = 0, bad = 0;
  int exp_q[$];
  bit bp = 1'b0;
  int sta_ch = 1023, sta_rssi = 0, sta_snr = 0, sta_imp = 0;
  int stb_ch = 1023, stb_rssi = 0, stb_snr = 0, stb_imp = 0;

  always #5 clk = ~clk;

  seek_tune_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tune_req(tune_req), .seek_req(seek_req),
    .seek_up(seek_up), .seek_stop(seek_stop), .spacing_sel(spacing_sel),
    .band_sel(band_sel), .chan_in(chan_in), .rssi_thresh(rssi_thresh),
    .snr_thresh(snr_thresh), .imp_thresh(imp_thresh),
    .meas_req_valid(meas_req_valid), .meas_req_ready(meas_req_ready),
    .meas_chan(meas_chan), .meas_rsp_valid(meas_rsp_valid),
    .meas_rsp_ready(meas_rsp_ready), .meas_rssi(meas_rssi), .meas_snr(meas_snr),
    .meas_imp(meas_imp), .done(done), .fail(fail), .cur_chan(cur_chan),
    .rssi_last(rssi_last), .freq_khz(freq_khz)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // measurement side: scoreboard monitor plus a responder with a small model
  initial begin
    int cyc = 0, dly = 0, pch = 0;
    bit pend = 0, rsp_fire = 0;
    forever begin
      @(negedge clk);
      cyc++;
      meas_req_ready = bp ? (cyc % 3 == 0) : 1'b1;
      if (rsp_fire) begin meas_rsp_valid = 1'b0; rsp_fire = 0; end
      if (meas_rsp_valid && meas_rsp_ready) rsp_fire = 1;
      if (meas_req_valid && meas_req_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R10 unexpected measurement", int'(meas_chan), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(meas_chan) == e, "R10 measured channel order", int'(meas_chan), e);
        end
        chk(cur_chan == meas_chan, "R10 cur_chan tracks step", int'(cur_chan), int'(meas_chan));
        pend = 1; dly = 2; pch = int'(meas_chan);
      end else if (pend) begin
        if (dly == 0) begin
          meas_rsp_valid = 1'b1;
          pend = 0;
          if (pch == sta_ch) begin
            meas_rssi = 8'(sta_rssi); meas_snr = 4'(sta_snr); meas_imp = 4'(sta_imp);
          end else if (pch == stb_ch) begin
            meas_rssi = 8'(stb_rssi); meas_snr = 4'(stb_snr); meas_imp = 4'(stb_imp);
          end else begin
            meas_rssi = 8'd10; meas_snr = 4'd2; meas_imp = 4'd9;
          end
        end else dly--;
      end
    end
  end

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic release_req(input string req);
    @(negedge clk);
    tune_req = 1'b0; seek_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(!done && !fail, req, int'({done, fail}), 0);
    chk(!meas_req_valid, req, int'(meas_req_valid), 0);
  endtask

  task automatic do_tune(input int ch, input int exp_freq);
    chan_in = 10'(ch);
    exp_q.push_back(ch);
    @(negedge clk); tune_req = 1'b1;
    wait_done();
    chk(done && !fail, "R1 tune completes", int'({done, fail}), 2);
    chk(int'(cur_chan) == ch, "R1 tune channel", int'(cur_chan), ch);
    chk(int'(freq_khz) == exp_freq, "R3 frequency", int'(freq_khz), exp_freq);
    chk(exp_q.size() == 0, "R1 single measurement", exp_q.size(), 0);
    release_req("R2 clear after tune");
  endtask

  // pushes the expected channel walk, starts a seek, checks the end state
  task automatic do_seek(input bit up, input bit stop, input int from, input int to_ch,
                         input int top, input bit exp_fail, input int end_ch, input string req);
    int c = from;
    seek_up = up; seek_stop = stop;
    while (c != to_ch) begin
      c = up ? ((c >= top) ? 0 : c + 1) : ((c == 0) ? top : c - 1);
      exp_q.push_back(c);
    end
    @(negedge clk); seek_req = 1'b1;
    wait_done();
    chk(done, {req, " done"}, int'(done), 1);
    chk(fail == exp_fail, {req, " fail"}, int'(fail), int'(exp_fail));
    chk(int'(cur_chan) == end_ch, {req, " end channel"}, int'(cur_chan), end_ch);
    chk(exp_q.size() == 0, {req, " steps"}, exp_q.size(), 0);
    exp_q.delete();
    release_req("R2 clear after seek");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !fail && cur_chan == 0, "R2 reset state", int'(cur_chan), 0);
    chk(freq_khz == 19'd87500, "R3 reset frequency", int'(freq_khz), 87500);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R4: top channel of band 0 at 100 kHz, plus other bands/spacings
    sta_ch = 205; sta_rssi = 77;
    spacing_sel = 2'd1; band_sel = 2'd0;
    chan_in = 10'd205; exp_q.push_back(205);
    @(negedge clk); tune_req = 1'b1;
    wait_done();
    chk(rssi_last == 8'd77, "R1 RSSI latched", int'(rssi_last), 77);
    repeat (20) @(negedge clk);
    chk(done && !meas_req_valid, "R2 done holds while request high", int'(done), 1);
    chk(freq_khz == 19'd108000, "R3 R4 band top", int'(freq_khz), 108000);
    release_req("R2 clear");
    sta_ch = 1023;

    band_sel = 2'd2; spacing_sel = 2'd2; do_tune(10, 76500);
    band_sel = 2'd1; spacing_sel = 2'd0; do_tune(3, 76600);
    band_sel = 2'd3; spacing_sel = 2'd3; do_tune(640, 108000);
    bp = 1'b1; band_sel = 2'd0; spacing_sel = 2'd0; do_tune(10, 89500);
    bp = 1'b0;

    // R5: seek up, station RSSI exactly at threshold
    sta_ch = 14; sta_rssi = 40; sta_snr = 3; sta_imp = 9;
    stb_ch = 16; stb_rssi = 60; stb_snr = 8; stb_imp = 4;
    do_seek(1, 0, 10, 14, 102, 0, 14, "R5 seek up at threshold");
    chk(rssi_last == 8'd40, "R5 RSSI at stop", int'(rssi_last), 40);

    // R6: SNR criterion rejects station A, station B passes
    do_tune(10, 89500);
    snr_thresh = 4'd5;
    do_seek(1, 0, 10, 16, 102, 0, 16, "R6 SNR criterion");
    snr_thresh = 4'd0;
    // R6: impulse criterion, count 9 rejected, count 4 equal to limit accepted
    do_tune(10, 89500);
    imp_thresh = 4'd4;
    do_seek(1, 0, 10, 16, 102, 0, 16, "R6 impulse criterion");
    imp_thresh = 4'd0;
    // R5: seek downward finds station B first from above
    do_tune(20, 91500);
    do_seek(0, 0, 20, 16, 102, 0, 16, "R5 seek down");

    // R7: wrap downward across channel 0 to the top
    sta_ch = 100; sta_rssi = 90; sta_snr = 0; sta_imp = 0; stb_ch = 1023;
    do_tune(1, 87700);
    do_seek(0, 0, 1, 100, 102, 0, 100, "R7 wrap down");

    // R8: full lap with no station in band 2 at 200 kHz (top 70)
    sta_ch = 1023;
    band_sel = 2'd2; spacing_sel = 2'd0;
    do_tune(5, 77000);
    do_seek(1, 0, 5, 4, 70, 1, 5, "R8 wrap fail returns to start");
    chk(freq_khz == 19'd77000, "R8 frequency after return", int'(freq_khz), 77000);

    // R9: stop mode halts at the upper edge, and at channel 0 going down
    do_tune(68, 89600);
    do_seek(1, 1, 68, 70, 70, 1, 70, "R9 stop at top edge");
    do_tune(0, 76000);
    do_seek(0, 1, 0, 0, 70, 1, 0, "R9 stop at bottom edge");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule